// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 16-bit operand address for an 8-bit processor core. The sequencer raises `start` with a mode code and an instruction-class tag. In that same cycle it presents the current index pair (H:X) and the stack pointer. The block captures both registers at `start`. It then takes zero, one or two operand bytes from program memory, one per cycle, and issues the address with a one-cycle `ea_vld` strobe.

The address is built in one of these ways:

- from the operand bytes directly (absolute addressing);
- from H:X, with no offset, a zero-extended 8-bit offset or a 16-bit offset;
- from the stack pointer plus a zero-extended 8-bit offset.

All of these share a single adder.

Two modes post-increment the index pair. For these, the block waits until the sequencer reports that the operand fetch is done with `fetch_done`. It then pulses `hx_wr` with H:X + 1 for the register file to store. Each of these modes is allowed only for certain instruction classes. A mode that is not legal for the class raises `illegal` for one cycle instead of an address, and it never causes a write-back.

Top module: `idx_ea_gen`

## Requirements
- R1: Mode 0 (absolute): `ea` = {first byte, second byte}, high byte first. `ea_vld` is high in the cycle after the second byte is accepted (`byte_vld` high).
- R2: Mode 1 (index, no offset): `ea` equals the `hx_in` value sampled with `start`. `ea_vld` is high in the cycle after `start`. Later changes of `hx_in` have no effect.
- R3: Mode 3 (index + 8-bit offset): `ea` = H:X + zero-extended byte (0x1000 + 0x80 = 0x1080). It is issued in the cycle after the byte is accepted.
- R4: Mode 5 (index + 16-bit offset): `ea` = H:X + {first byte, second byte}. It is issued in the cycle after the second byte.
- R5: Mode 6 (stack + 8-bit offset): `ea` = `sp_in` (sampled with `start`) + zero-extended byte.
- R6: Every address sum wraps modulo 2^16, for example 0xFFF0 + 0x0020 = 0x0010.
- R7: Mode 2 (index, post-increment) is legal for class 1 (move) and class 2 (compare-and-branch). `ea` = H:X. One cycle after `fetch_done`, `hx_wr` pulses with `hx_wr_data` = H:X + 1, and 0xFFFF wraps to 0x0000.
- R8: Mode 4 (index + 8-bit offset, post-increment) is legal only for class 2. `ea` = H:X + zero-extended byte, and the write-back is H:X + 1, as in R7.
- R9: Illegal requests raise `illegal` for one cycle, in the cycle after `start`, with no `ea_vld` and no `hx_wr`. The illegal requests are: mode 2 with class 0 or 3, mode 4 with a class other than 2, and mode 7.
- R10: The write-back waits for `fetch_done` however late it arrives. `ea` keeps the issued address while `hx_wr` pulses. A `fetch_done` when no write-back is pending has no effect.
- R11: While `rst_n` is low at a clock edge, `ea_vld`, `illegal` and `hx_wr` go low and `ea` goes to 0.
- R12: A cycle with `byte_vld` low stalls byte collection without loss. A `start` while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a request; mode, class, H:X and SP are sampled |
| mode | input | 3 | Addressing mode code (0..7) |
| iclass | input | 2 | Instruction-class tag: 0 generic, 1 move, 2 compare-and-branch, 3 other |
| hx_in | input | 16 | Current index pair value |
| sp_in | input | 16 | Current stack pointer value |
| byte_vld | input | 1 | An operand byte is present on `byte_data` |
| byte_data | input | 8 | Operand byte from program memory |
| fetch_done | input | 1 | The operand at `ea` has been fetched |
| ea | output | 16 | Effective address, held until the next result |
| ea_vld | output | 1 | One-cycle strobe: `ea` is new |
| illegal | output | 1 | One-cycle strobe: the mode is not legal for the class |
| hx_wr | output | 1 | One-cycle strobe: store `hx_wr_data` into H:X |
| hx_wr_data | output | 16 | Incremented index pair |

## Verification
The hardest cases to reach from the ports involve the write-back wait state. One is a `fetch_done` that arrives several cycles late. Another is the increment of 0xFFFF that must wrap. A third is a second `start` that lands while the block is still collecting operand bytes.

The stimulus reaches these cases as follows:

- It holds `fetch_done` back by a chosen gap after the address strobe.
- It pokes `start` with a zero-byte mode one cycle into an absolute request.
- It drives a stray `fetch_done` while the block is idle.

The scoreboard flags any output it did not expect. Every strobe is also checked against the cycle it is due in.

// File: rtl/idx_ea_pkg.sv
// Package: shared encodings for the effective address generator.
// Assumes: mode and class codes are fixed by the instruction decoder.
package idx_ea_pkg;

    // Addressing mode codes presented on the mode input
    typedef enum logic [2:0] {
        MODE_ABS         = 3'd0,
        MODE_HX          = 3'd1,
        MODE_HX_INC      = 3'd2,
        MODE_HX_OFF8     = 3'd3,
        MODE_HX_OFF8_INC = 3'd4,
        MODE_HX_OFF16    = 3'd5,
        MODE_SP_OFF8     = 3'd6,
        MODE_RSVD        = 3'd7
    } mode_e;

    // Instruction-class tags used for legality of post-increment modes
    typedef enum logic [1:0] {
        CLS_GEN   = 2'd0,
        CLS_MOVE  = 2'd1,
        CLS_CMPBR = 2'd2,
        CLS_OTHER = 2'd3
    } class_e;

    // Base operand chosen for the shared adder
    typedef enum logic [1:0] {
        BASE_NONE = 2'd0,
        BASE_HX   = 2'd1,
        BASE_SP   = 2'd2
    } base_e;

    // Request sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HI   = 2'd1,
        ST_LO   = 2'd2,
        ST_WAIT = 2'd3
    } state_e;

endpackage

// File: rtl/idx_ea_decode.sv
// Module: idx_ea_decode
// Purely combinational decode of a mode code and class tag into the
// request shape: legality, number of operand bytes, base register,
// offset width and whether H:X is post-incremented.
// Assumes: the result is sampled only together with start.
module idx_ea_decode
    import idx_ea_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] iclass,
    output logic       legal,
    output logic [1:0] nbytes,
    output logic       inc,
    output logic       wide,
    output base_e      base
);

    // Decode table: one arm per mode code
    always_comb begin
        legal  = 1'b1;
        nbytes = 2'd0;
        inc    = 1'b0;
        wide   = 1'b0;
        base   = BASE_HX;
        case (mode)
            MODE_ABS: begin
                nbytes = 2'd2;
                wide   = 1'b1;
                base   = BASE_NONE;
            end
            MODE_HX: begin
                nbytes = 2'd0;
            end
            MODE_HX_INC: begin
                inc   = 1'b1;
                legal = (iclass == CLS_MOVE) || (iclass == CLS_CMPBR);
            end
            MODE_HX_OFF8: begin
                nbytes = 2'd1;
            end
            MODE_HX_OFF8_INC: begin
                nbytes = 2'd1;
                inc    = 1'b1;
                legal  = (iclass == CLS_CMPBR);
            end
            MODE_HX_OFF16: begin
                nbytes = 2'd2;
                wide   = 1'b1;
            end
            MODE_SP_OFF8: begin
                nbytes = 2'd1;
                base   = BASE_SP;
            end
            default: begin
                legal = 1'b0;
                base  = BASE_NONE;
            end
        endcase
    end

endmodule

// File: rtl/idx_ea_adder.sv
// Module: idx_ea_adder
// The single address adder shared by every mode: selects a base
// (none, H:X or SP), zero-extends or concatenates the offset bytes,
// and adds modulo 2^AW.
// Assumes: AW is twice BW so two bytes form a full offset.
module idx_ea_adder
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  base_e          base_sel,
    input  logic [AW-1:0]  hx,
    input  logic [AW-1:0]  sp,
    input  logic [BW-1:0]  hi,
    input  logic [BW-1:0]  lo,
    input  logic           wide,
    output logic [AW-1:0]  sum
);

    localparam int PADW = AW - BW;

    logic [AW-1:0] base_val;
    logic [AW-1:0] off_val;

    // Base register multiplexer
    always_comb begin
        case (base_sel)
            BASE_HX: base_val = hx;
            BASE_SP: base_val = sp;
            default: base_val = '0;
        endcase
    end

    // Offset formation: two bytes high first, or one byte zero-extended
    always_comb begin
        if (wide) off_val = AW'({hi, lo});
        else      off_val = {{PADW{1'b0}}, lo};
    end

    // Wrapping sum
    always_comb sum = base_val + off_val;

endmodule

// File: rtl/idx_ea_ctrl.sv
// Module: idx_ea_ctrl
// Sequencer: samples a request on start, collects operand bytes,
// drives the shared adder, registers the address strobe, flags illegal
// requests and issues the gated H:X write-back after fetch_done.
// Assumes: the decode inputs belong to the mode/class presented with
// start; byte_data is meaningful only while byte_vld is high.
module idx_ea_ctrl
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dec_legal,
    input  logic [1:0]    dec_nbytes,
    input  logic          dec_inc,
    input  logic          dec_wide,
    input  base_e         dec_base,
    input  logic [AW-1:0] hx_in,
    input  logic [AW-1:0] sp_in,
    input  logic          byte_vld,
    input  logic [BW-1:0] byte_data,
    input  logic          fetch_done,
    input  logic [AW-1:0] sum,
    output base_e         op_base,
    output logic [AW-1:0] op_hx,
    output logic [AW-1:0] op_sp,
    output logic [BW-1:0] op_hi,
    output logic [BW-1:0] op_lo,
    output logic          op_wide,
    output logic [AW-1:0] ea,
    output logic          ea_vld,
    output logic          illegal,
    output logic          hx_wr,
    output logic [AW-1:0] hx_wr_data
);

    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    state_e        state_q, state_d;
    base_e         base_q;
    logic          wide_q;
    logic          inc_q;
    logic [AW-1:0] hx_q;
    logic [AW-1:0] sp_q;
    logic [BW-1:0] hi_q;
    logic          idle;
    logic          take;
    logic          fire_now;
    logic          fire_byte;

    // Request acceptance and address issue conditions
    always_comb begin
        idle      = (state_q == ST_IDLE);
        take      = idle && start;
        fire_now  = take && dec_legal && (dec_nbytes == 2'd0);
        fire_byte = (state_q == ST_LO) && byte_vld;
    end

    // Adder operands: live inputs for zero-byte issue, captured otherwise
    always_comb begin
        if (idle) begin
            op_base = dec_legal ? dec_base : BASE_NONE;
            op_hx   = hx_in;
            op_sp   = sp_in;
            op_hi   = '0;
            op_lo   = '0;
            op_wide = 1'b0;
        end else begin
            op_base = base_q;
            op_hx   = hx_q;
            op_sp   = sp_q;
            op_hi   = hi_q;
            op_lo   = byte_data;
            op_wide = wide_q;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (start && dec_legal) begin
                    case (dec_nbytes)
                        2'd0:    state_d = dec_inc ? ST_WAIT : ST_IDLE;
                        2'd1:    state_d = ST_LO;
                        default: state_d = ST_HI;
                    endcase
                end
            end
            ST_HI:   if (byte_vld)   state_d = ST_LO;
            ST_LO:   if (byte_vld)   state_d = inc_q ? ST_WAIT : ST_IDLE;
            ST_WAIT: if (fetch_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture at start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= BASE_NONE;
            wide_q <= 1'b0;
            inc_q  <= 1'b0;
            hx_q   <= '0;
            sp_q   <= '0;
        end else if (take) begin
            base_q <= dec_base;
            wide_q <= dec_wide;
            inc_q  <= dec_inc;
            hx_q   <= hx_in;
            sp_q   <= sp_in;
        end
    end

    // High offset/address byte capture
    always_ff @(posedge clk) begin
        if (!rst_n)                         hi_q <= '0;
        else if (state_q == ST_HI && byte_vld) hi_q <= byte_data;
    end

    // Registered address and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea      <= '0;
            ea_vld  <= 1'b0;
            illegal <= 1'b0;
        end else begin
            ea_vld  <= fire_now || fire_byte;
            illegal <= take && !dec_legal;
            if (fire_now || fire_byte) ea <= sum;
        end
    end

    // Gated H:X write-back after the operand fetch completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hx_wr      <= 1'b0;
            hx_wr_data <= '0;
        end else begin
            hx_wr <= (state_q == ST_WAIT) && fetch_done;
            if ((state_q == ST_WAIT) && fetch_done) hx_wr_data <= hx_q + ONE;
        end
    end

endmodule

// File: rtl/idx_ea_gen.sv
// Module: idx_ea_gen (top)
// Effective address generator: decode, shared adder and sequencer.
// Assumes: one request at a time; the sequencer waits for ea_vld or
// illegal (and hx_wr for post-increment modes) before the next start.
module idx_ea_gen
    import idx_ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [1:0]    iclass,
    input  logic [AW-1:0] hx_in,
    input  logic [AW-1:0] sp_in,
    input  logic          byte_vld,
    input  logic [BW-1:0] byte_data,
    input  logic          fetch_done,
    output logic [AW-1:0] ea,
    output logic          ea_vld,
    output logic          illegal,
    output logic          hx_wr,
    output logic [AW-1:0] hx_wr_data
);

    logic          dec_legal;
    logic [1:0]    dec_nbytes;
    logic          dec_inc;
    logic          dec_wide;
    base_e         dec_base;
    base_e         op_base;
    logic [AW-1:0] op_hx;
    logic [AW-1:0] op_sp;
    logic [BW-1:0] op_hi;
    logic [BW-1:0] op_lo;
    logic          op_wide;
    logic [AW-1:0] sum;

    idx_ea_decode u_decode (
        .mode   (mode),
        .iclass (iclass),
        .legal  (dec_legal),
        .nbytes (dec_nbytes),
        .inc    (dec_inc),
        .wide   (dec_wide),
        .base   (dec_base)
    );

    idx_ea_adder #(.AW(AW), .BW(BW)) u_adder (
        .base_sel (op_base),
        .hx       (op_hx),
        .sp       (op_sp),
        .hi       (op_hi),
        .lo       (op_lo),
        .wide     (op_wide),
        .sum      (sum)
    );

    idx_ea_ctrl #(.AW(AW), .BW(BW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dec_legal  (dec_legal),
        .dec_nbytes (dec_nbytes),
        .dec_inc    (dec_inc),
        .dec_wide   (dec_wide),
        .dec_base   (dec_base),
        .hx_in      (hx_in),
        .sp_in      (sp_in),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .fetch_done (fetch_done),
        .sum        (sum),
        .op_base    (op_base),
        .op_hx      (op_hx),
        .op_sp      (op_sp),
        .op_hi      (op_hi),
        .op_lo      (op_lo),
        .op_wide    (op_wide),
        .ea         (ea),
        .ea_vld     (ea_vld),
        .illegal    (illegal),
        .hx_wr      (hx_wr),
        .hx_wr_data (hx_wr_data)
    );

endmodule

// File: rtl/idx_ea_chk.sv
// Module: idx_ea_chk
// Temporal checks on the top-level ports of idx_ea_gen, attached by bind.
// Assumes: synchronous active-low reset.
module idx_ea_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          fetch_done,
    input logic [AW-1:0] ea,
    input logic          ea_vld,
    input logic          illegal,
    input logic          hx_wr
);

    // R11: reset clears every strobe on the following cycle
    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |=> (!ea_vld && !illegal && !hx_wr));

    // R9: an illegal flag answers a start of the previous cycle
    p_illegal_follows_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(start));

    // R9: an illegal request issues no address and no write-back
    p_illegal_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!ea_vld && !hx_wr));

    // R10: a write-back only answers a fetch-done of the previous cycle
    p_wr_after_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hx_wr |-> $past(fetch_done));

    // R10: the issued address is untouched by the write-back
    p_wr_keeps_ea_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hx_wr |-> ($stable(ea) && !ea_vld));

    // R2: the address output moves only together with its strobe
    p_ea_moves_with_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ea) |-> ea_vld);

endmodule

bind idx_ea_gen idx_ea_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fetch_done (fetch_done),
    .ea         (ea),
    .ea_vld     (ea_vld),
    .illegal    (illegal),
    .hx_wr      (hx_wr)
);

// File: tb/idx_ea_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for idx_ea_gen. The driver pushes expected strobes
// (kind, value, due cycle) into queues; a monitor pops and compares.
module idx_ea_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [1:0]  iclass = '0;
    logic [15:0] hx_in = '0;
    logic [15:0] sp_in = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        fetch_done = 1'b0;
    logic [15:0] ea;
    logic        ea_vld;
    logic        illegal;
    logic        hx_wr;
    logic [15:0] hx_wr_data;

    int n_chk = 0;
    int n_bad = 0;
    int n_unexp = 0;
    int cyc = 0;
    bit done = 1'b0;

    int          qk[$];
    logic [15:0] qv[$];
    logic [15:0] qh[$];
    int          qd[$];
    string       qt[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    idx_ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .iclass(iclass),
        .hx_in(hx_in), .sp_in(sp_in), .byte_vld(byte_vld), .byte_data(byte_data),
        .fetch_done(fetch_done), .ea(ea), .ea_vld(ea_vld), .illegal(illegal),
        .hx_wr(hx_wr), .hx_wr_data(hx_wr_data)
    );

    task automatic push(input int k, input logic [15:0] v, input logic [15:0] h,
                        input int due, input string tag);
        qk.push_back(k); qv.push_back(v); qh.push_back(h);
        qd.push_back(due); qt.push_back(tag);
    endtask

    // Monitor side: compare one observed strobe against the queue head
    task automatic observe(input int k, input logic [15:0] v);
        int ek; logic [15:0] ev, eh; int ed; string et;
        n_chk++;
        if (qk.size() == 0) begin
            n_bad++; n_unexp++;
            $display("FAIL R10/R12 unexpected strobe kind=%0d value=%h at cycle %0d (expected none)",
                     k, v, cyc);
            return;
        end
        ek = qk.pop_front(); ev = qv.pop_front(); eh = qh.pop_front();
        ed = qd.pop_front(); et = qt.pop_front();
        if (ek != k || ev != v || ed != cyc || (k == 2 && ea != eh)) begin
            n_bad++;
            $display("FAIL %s kind=%0d value=%h cycle=%0d ea=%h (expected kind=%0d value=%h cycle=%0d ea=%h)",
                     et, k, v, cyc, ea, ek, ev, ed, eh);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ea_vld)  observe(0, ea);
            if (illegal) observe(1, 16'h0000);
            if (hx_wr)   observe(2, hx_wr_data);
        end
    end

    // All expected strobes must have appeared
    task automatic drain(input string tag);
        n_chk++;
        if (qk.size() != 0) begin
            n_bad++;
            $display("FAIL %s missing %0d strobe(s), next kind=%0d value=%h (expected queue empty)",
                     tag, qk.size(), qk[0], qv[0]);
            qk.delete(); qv.delete(); qh.delete(); qd.delete(); qt.delete();
        end
    endtask

    // Reference model derived from the requirements
    task automatic model(input logic [2:0] m, input logic [1:0] c,
                         input logic [15:0] hx, input logic [15:0] sp,
                         input logic [7:0] b0, input logic [7:0] b1,
                         output bit lg, output int nb, output bit pi,
                         output logic [15:0] exp_ea);
        lg = 1'b1; nb = 0; pi = 1'b0; exp_ea = 16'h0;
        case (m)
            3'd0: begin nb = 2; exp_ea = {b0, b1}; end
            3'd1: exp_ea = hx;
            3'd2: begin pi = 1'b1; exp_ea = hx; lg = (c == 2'd1 || c == 2'd2); end
            3'd3: begin nb = 1; exp_ea = hx + {8'h00, b0}; end
            3'd4: begin nb = 1; pi = 1'b1; exp_ea = hx + {8'h00, b0}; lg = (c == 2'd2); end
            3'd5: begin nb = 2; exp_ea = hx + {b0, b1}; end
            3'd6: begin nb = 1; exp_ea = sp + {8'h00, b0}; end
            default: lg = 1'b0;
        endcase
    endtask

    // Driver: one complete request
    task automatic op(input logic [2:0] m, input logic [1:0] c,
                      input logic [15:0] hx, input logic [15:0] sp,
                      input logic [7:0] b0, input logic [7:0] b1,
                      input int stall, input int fgap, input bit poke,
                      input string tag);
        bit lg; int nb; bit pi; logic [15:0] e;
        model(m, c, hx, sp, b0, b1, lg, nb, pi, e);
        @(negedge clk);
        start = 1'b1; mode = m; iclass = c; hx_in = hx; sp_in = sp;
        if (!lg)          push(1, 16'h0, 16'h0, cyc + 1, tag);
        else if (nb == 0) push(0, e, 16'h0, cyc + 1, tag);
        @(negedge clk);
        if (poke) begin
            mode = 3'd1; iclass = 2'd0; hx_in = 16'h5A5A;
            @(negedge clk);
        end
        start = 1'b0; hx_in = ~hx; sp_in = ~sp;
        if (lg) begin
            for (int i = 0; i < nb; i++) begin
                for (int s = 0; s < stall; s++) begin
                    byte_vld = 1'b0; byte_data = 8'hC3;
                    @(negedge clk);
                end
                byte_vld = 1'b1;
                byte_data = (i == 0) ? b0 : b1;
                if (i == nb - 1) push(0, e, 16'h0, cyc + 1, tag);
                @(negedge clk);
                byte_vld = 1'b0; byte_data = 8'h00;
            end
            if (pi) begin
                for (int g = 0; g < fgap; g++) @(negedge clk);
                fetch_done = 1'b1;
                push(2, hx + 16'h0001, e, cyc + 1, tag);
                @(negedge clk);
                fetch_done = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        drain(tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired (expected run to finish)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int unexp_before;
        repeat (4) @(negedge clk);
        // R11: outputs after reset
        n_chk++;
        if (ea_vld || illegal || hx_wr || ea != 16'h0) begin
            n_bad++;
            $display("FAIL R11 reset state vld=%b ill=%b wr=%b ea=%h (expected 0 0 0 0000)",
                     ea_vld, illegal, hx_wr, ea);
        end
        rst_n = 1'b1;
        @(negedge clk);

        op(3'd0, 2'd0, 16'h7777, 16'h0000, 8'h12, 8'h34, 0, 0, 1'b0, "R1");
        op(3'd0, 2'd0, 16'h0000, 16'h0000, 8'hAB, 8'hCD, 2, 0, 1'b0, "R12");    // stalled bytes
        op(3'd1, 2'd0, 16'hBEEF, 16'h1111, 8'h00, 8'h00, 0, 0, 1'b0, "R2");
        op(3'd3, 2'd0, 16'h1000, 16'h0000, 8'h80, 8'h00, 0, 0, 1'b0, "R3");
        op(3'd3, 2'd3, 16'h0042, 16'h0000, 8'hFF, 8'h00, 1, 0, 1'b0, "R3");
        op(3'd5, 2'd0, 16'h0100, 16'h0000, 8'h20, 8'h05, 0, 0, 1'b0, "R4");
        op(3'd6, 2'd0, 16'h4444, 16'h00FF, 8'hFF, 8'h00, 0, 0, 1'b0, "R5");
        op(3'd5, 2'd0, 16'hFFF0, 16'h0000, 8'h00, 8'h20, 0, 0, 1'b0, "R6");
        op(3'd3, 2'd0, 16'hFFFF, 16'h0000, 8'h01, 8'h00, 0, 0, 1'b0, "R6");
        op(3'd6, 2'd0, 16'h0000, 16'hFFFE, 8'h05, 8'h00, 0, 0, 1'b0, "R6");
        op(3'd2, 2'd1, 16'h3000, 16'h0000, 8'h00, 8'h00, 0, 0, 1'b0, "R7");
        op(3'd2, 2'd2, 16'hFFFF, 16'h0000, 8'h00, 8'h00, 1, 2, 1'b0, "R7");
        op(3'd4, 2'd2, 16'h2000, 16'h0000, 8'h10, 8'h00, 0, 0, 1'b0, "R8");
        op(3'd2, 2'd0, 16'h3000, 16'h0000, 8'h00, 8'h00, 0, 0, 1'b0, "R9");
        op(3'd2, 2'd3, 16'h3000, 16'h0000, 8'h00, 8'h00, 0, 0, 1'b0, "R9");
        op(3'd4, 2'd1, 16'h2000, 16'h0000, 8'h10, 8'h00, 0, 0, 1'b0, "R9");
        op(3'd7, 2'd2, 16'h2000, 16'h0000, 8'h10, 8'h00, 0, 0, 1'b0, "R9");
        op(3'd4, 2'd2, 16'h8000, 16'h0000, 8'hF0, 8'h00, 0, 6, 1'b0, "R10");   // late fetch
        op(3'd0, 2'd0, 16'h0000, 16'h0000, 8'h9A, 8'hBC, 0, 0, 1'b1, "R12");   // start while busy

        // R10: stray fetch_done while idle has no effect
        unexp_before = n_unexp;
        @(negedge clk); fetch_done = 1'b1;
        @(negedge clk); fetch_done = 1'b0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (n_unexp != unexp_before) begin
            n_bad++;
            $display("FAIL R10 stray fetch_done produced %0d strobe(s) (expected 0)",
                     n_unexp - unexp_before);
        end
        drain("R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule